// File: doc/BRIEF.md
# Key-Refreshed Watchdog Timer

This block is a watchdog counter clocked by a slow free-running clock. Three static option inputs set it up: an enable bit, a 3-bit period select and a bit that keeps it counting during halt or stop. Software keeps it quiet by writing the key byte 0xAC to its refresh register. A wrong byte, any single-bit (read-modify-write) access, or a counter that reaches the selected limit makes the block raise a one-cycle internal reset request. After the request fires, the block stays silent until the chip applies an external reset.

The control is a five-state machine:
- `ST_BOOT` is the decode cycle after reset. It goes to `ST_RUN` when the options allow counting and to `ST_STOPPED` when they do not.
- `ST_RUN` goes to `ST_FROZEN` on standby when standby counting is off.
- `ST_FROZEN` goes back to `ST_RUN` on standby release, and the counter is cleared on the way.
- Every state except `ST_TRIPPED` goes to `ST_TRIPPED` on a bad access.
- `ST_RUN` also goes to `ST_TRIPPED` on overflow.
- `ST_TRIPPED` is final until reset.

Top module: `keyed_watchdog`

## Requirements
- R1: While reset is asserted and in the first clock after reset release, `rst_req` is 0 and no cycle is counted (that clock is the option decode cycle).
- R2: With `opt_enable`=1 and no writes, the first `rst_req` pulse appears after clock edge 1 + 2^(7+n) counted from reset release, where n is `opt_period_sel`.
- R3: `rst_req` is high for exactly one clock cycle per trip.
- R4: A write (`wr_en`=1, `wr_bitop`=0) of 0xAC while counting clears the counter, so the next pulse follows 2^(7+n) edges after the write edge.
- R5: A valid 0xAC write on the very edge on which the limit would be reached wins, and no pulse is raised on that edge.
- R6: A write of any byte other than 0xAC with `wr_bitop`=0 raises `rst_req` after the write edge. This applies in every state except the tripped one, including the stopped state.
- R7: A write with `wr_bitop`=1 raises `rst_req` after the write edge whatever its data, including 0xAC.
- R8: With `opt_enable`=0 the counter never runs and a 0xAC write has no effect; no pulse appears without a bad access.
- R9: `opt_enable`=0 together with `opt_standby_run`=1 is a configuration error, and the counter stays stopped.
- R10: With `opt_standby_run`=0, counting freezes while `standby`=1. The release edge clears the counter, and the pulse follows 2^(7+n) edges after that edge.
- R11: With `opt_standby_run`=1, `standby` has no effect on the overflow timing.
- R12: After a pulse, no further pulse appears until an external reset, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_enable | input | 1 | Option: start counting after reset |
| opt_period_sel | input | 3 | Option: overflow period select n, limit 2^(7+n) |
| opt_standby_run | input | 1 | Option: keep counting in standby |
| wr_en | input | 1 | Refresh register write strobe |
| wr_data | input | 8 | Refresh register write data |
| wr_bitop | input | 1 | Marks the write as a single-bit manipulation access |
| standby | input | 1 | Halt/stop indication |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The main function is tried in several ways:
- Undisturbed counting at period selects 0, 2 and 7. This separates a correct limit from off-by-one or wrongly shifted thresholds.
- A refresh mid-period and a refresh on the final edge. These separate a real clear from a missed one, and show refresh-over-overflow priority.
- Wrong bytes and single-bit accesses carrying the key. These separate key checking from mere write detection.
- Standby windows under both standby options, together with the disabled and illegal option pairs. These show whether freezing, clearing on release and stopping act only where they should.

A behavioural model runs alongside and is compared on every clock.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_STOPPED,
        ST_RUN,
        ST_FROZEN,
        ST_TRIPPED
    } kwd_state_e;

    typedef struct packed {
        logic refresh;
        logic breach;
    } kwd_access_t;

endpackage

// File: rtl/kwd_cfg.sv
module kwd_cfg #(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 7,
    parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             opt_enable,
    input  logic [SEL_W-1:0] opt_period_sel,
    input  logic             opt_standby_run,
    output logic             run_ok,
    output logic             cfg_err,
    output logic             freeze_en,
    output logic [CNT_W-1:0] last_val
);
    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] lim_tab [NSEL];

    // one terminal count per select value: 2^(BASE_EXP+g) - 1
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
    end

    assign cfg_err   = !opt_enable && opt_standby_run;
    assign run_ok    = opt_enable && !cfg_err;
    assign freeze_en = !opt_standby_run;
    assign last_val  = lim_tab[opt_period_sel];

endmodule

// File: rtl/kwd_access.sv
module kwd_access
    import kwd_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEY    = 8'hAC
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bitop,
    output kwd_access_t       acc
);
    logic key_hit;

    assign key_hit     = (wr_data == DATA_W'(KEY));
    assign acc.refresh = wr_en && !wr_bitop && key_hit;
    assign acc.breach  = wr_en && (wr_bitop || !key_hit);

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             cnt_inc,
    input  logic [CNT_W-1:0] last_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else if (cnt_inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt     = cnt_q;
    assign at_last = (cnt_q == last_val);

endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_ok,
    input  logic        cfg_err,
    input  logic        freeze_en,
    input  logic        standby,
    input  kwd_access_t acc,
    input  logic        at_last,
    output logic        cnt_clr,
    output logic        cnt_inc,
    output logic        rst_req,
    output kwd_state_e  state
);
    kwd_state_e state_q, state_d;
    logic       hold_now;
    logic       fire;
    logic       rst_req_q;

    assign hold_now = standby && freeze_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: begin
                if (acc.breach)                 state_d = ST_TRIPPED;
                else if (run_ok && !cfg_err)    state_d = ST_RUN;
                else                            state_d = ST_STOPPED;
            end
            ST_STOPPED: begin
                if (acc.breach)                 state_d = ST_TRIPPED;
            end
            ST_RUN: begin
                if (acc.breach)                 state_d = ST_TRIPPED;
                else if (acc.refresh)           state_d = hold_now ? ST_FROZEN : ST_RUN;
                else if (hold_now)              state_d = ST_FROZEN;
                else if (at_last)               state_d = ST_TRIPPED;
            end
            ST_FROZEN: begin
                if (acc.breach)                 state_d = ST_TRIPPED;
                else if (!standby)              state_d = ST_RUN;
            end
            ST_TRIPPED: begin
                state_d = ST_TRIPPED;
            end
            default: state_d = ST_TRIPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fire    = 1'b0;
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_BOOT, ST_STOPPED: begin
                fire    = acc.breach;
                cnt_clr = 1'b1;
            end
            ST_RUN: begin
                if (acc.breach) begin
                    fire    = 1'b1;
                    cnt_clr = 1'b1;
                end else if (acc.refresh) begin
                    cnt_clr = 1'b1;
                end else if (hold_now) begin
                    cnt_clr = 1'b0;
                end else if (at_last) begin
                    fire    = 1'b1;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_FROZEN: begin
                fire    = acc.breach;
                cnt_clr = acc.breach || acc.refresh || !standby;
            end
            ST_TRIPPED: begin
                cnt_clr = 1'b1;
            end
            default: cnt_clr = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req_q <= 1'b0;
        else        rst_req_q <= fire;
    end

    assign rst_req = rst_req_q;
    assign state   = state_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int         SEL_W    = 3,
    parameter int         BASE_EXP = 7,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] KEY      = 8'hAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_enable,
    input  logic [SEL_W-1:0]  opt_period_sel,
    input  logic              opt_standby_run,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bitop,
    input  logic              standby,
    output logic              rst_req
);
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

    logic             run_ok;
    logic             cfg_err;
    logic             freeze_en;
    logic [CNT_W-1:0] last_val;
    kwd_access_t      acc;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;
    kwd_state_e       state_q;

    kwd_cfg #(
        .SEL_W    (SEL_W),
        .BASE_EXP (BASE_EXP),
        .CNT_W    (CNT_W)
    ) u_cfg (
        .opt_enable      (opt_enable),
        .opt_period_sel  (opt_period_sel),
        .opt_standby_run (opt_standby_run),
        .run_ok          (run_ok),
        .cfg_err         (cfg_err),
        .freeze_en       (freeze_en),
        .last_val        (last_val)
    );

    kwd_access #(
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_access (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_bitop (wr_bitop),
        .acc      (acc)
    );

    kwd_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .last_val (last_val),
        .cnt      (cnt_q),
        .at_last  (at_last)
    );

    kwd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_ok    (run_ok),
        .cfg_err   (cfg_err),
        .freeze_en (freeze_en),
        .standby   (standby),
        .acc       (acc),
        .at_last   (at_last),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .rst_req   (rst_req),
        .state     (state_q)
    );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int         CNT_W  = 14,
    parameter int         DATA_W = 8,
    parameter logic [7:0] KEY    = 8'hAC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              opt_enable,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_bitop,
    input logic              standby,
    input logic              opt_standby_run,
    input logic              rst_req,
    input kwd_state_e        state,
    input logic [CNT_W-1:0]  cnt
);
    logic key_w;
    assign key_w = wr_en && !wr_bitop && (wr_data == DATA_W'(KEY));

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_req_marks_trip_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> state == ST_TRIPPED);

    assert_trip_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TRIPPED |=> state == ST_TRIPPED && !rst_req);

    assert_bad_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bitop && wr_data != DATA_W'(KEY) && state != ST_TRIPPED) |=> rst_req);

    assert_bitop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bitop && state != ST_TRIPPED) |=> rst_req);

    assert_refresh_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_w && state == ST_RUN) |=> cnt == '0 && !rst_req);

    assert_no_run_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_enable |-> state != ST_RUN && state != ST_FROZEN);

    assert_frozen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && standby && !wr_en) |=> cnt == $past(cnt));

    assert_release_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && !standby && !wr_en) |=> cnt == '0 && state == ST_RUN);

    assert_no_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        opt_standby_run |-> state != ST_FROZEN);

endmodule

bind keyed_watchdog kwd_checker #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .KEY    (KEY)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .opt_enable      (opt_enable),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .wr_bitop        (wr_bitop),
    .standby         (standby),
    .opt_standby_run (opt_standby_run),
    .rst_req         (rst_req),
    .state           (state_q),
    .cnt             (cnt_q)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opt_enable = 1'b0;
    logic [2:0] opt_period_sel = 3'd0;
    logic       opt_standby_run = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_bitop = 1'b0;
    logic       standby = 1'b0;
    logic       rst_req;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc;
    int    pulse_at = 0;
    int    pulse_n  = 0;
    int    wd = 0;
    string tag = "R1";

    // reference model state: 0 boot,1 stopped,2 run,3 frozen,4 tripped
    int m_st;
    int m_cnt;
    bit m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk             (clk),
        .rst_n           (rst_n),
        .opt_enable      (opt_enable),
        .opt_period_sel  (opt_period_sel),
        .opt_standby_run (opt_standby_run),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .wr_bitop        (wr_bitop),
        .standby         (standby),
        .rst_req         (rst_req)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(posedge clk or negedge rst_n) begin
        bit bad, good, hold;
        int lim;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_req = 0;
        end else begin
            bad  = wr_en && (wr_bitop || wr_data != 8'hAC);
            good = wr_en && !bad;
            hold = standby && !opt_standby_run;
            lim  = 128 << opt_period_sel;
            m_req = 0;
            if (m_st != 4 && bad) begin
                m_st = 4; m_req = 1; m_cnt = 0;
            end else begin
                case (m_st)
                    0: m_st = (opt_enable) ? 2 : 1;
                    2: begin
                        if (good) begin
                            m_cnt = 0;
                            if (hold) m_st = 3;
                        end else if (hold) begin
                            m_st = 3;
                        end else begin
                            m_cnt = m_cnt + 1;
                            if (m_cnt == lim) begin
                                m_st = 4; m_req = 1; m_cnt = 0;
                            end
                        end
                    end
                    3: begin
                        if (good) m_cnt = 0;
                        if (!standby) begin
                            m_cnt = 0; m_st = 2;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (rst_req !== m_req) begin
                n_fail++;
                $display("FAIL %s cycle %0d: rst_req actual %0b expected %0b", tag, cyc, rst_req, m_req);
            end
            if (rst_req === 1'b1) begin
                pulse_n++;
                if (pulse_at == 0) pulse_at = cyc;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", wd, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(int act, int exp, string req);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(bit en, logic [2:0] sel, bit srun);
        @(negedge clk);
        rst_n = 1'b0;
        opt_enable = en; opt_period_sel = sel; opt_standby_run = srun;
        wr_en = 1'b0; wr_bitop = 1'b0; wr_data = 8'h00; standby = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(rst_req), 0, "R1 reset");
        pulse_at = 0; pulse_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic idle_until(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // drives a write that the design samples on edge e
    task automatic write_at(int e, logic [7:0] d, bit bop);
        idle_until(e - 1);
        wr_en = 1'b1; wr_data = d; wr_bitop = bop;
        @(negedge clk);
        wr_en = 1'b0; wr_bitop = 1'b0; wr_data = 8'h00;
    endtask

    initial begin
        // R1, R2, R3, R12
        tag = "R2";
        do_reset(1'b1, 3'd0, 1'b0);
        @(negedge clk);
        check(int'(rst_req), 0, "R1 decode cycle");
        idle_until(135);
        check(pulse_at, 129, "R2 sel0 period");
        check(pulse_n, 1, "R3 single pulse");
        tag = "R12";
        write_at(150, 8'h00, 1'b0);
        write_at(160, 8'hAC, 1'b1);
        idle_until(400);
        check(pulse_n, 1, "R12 silent after trip");

        tag = "R2";
        do_reset(1'b1, 3'd2, 1'b0);
        idle_until(520);
        check(pulse_at, 513, "R2 sel2 period");

        tag = "R4";
        do_reset(1'b1, 3'd0, 1'b0);
        write_at(60, 8'hAC, 1'b0);
        idle_until(200);
        check(pulse_at, 188, "R4 refresh restarts");

        tag = "R5";
        do_reset(1'b1, 3'd0, 1'b0);
        write_at(129, 8'hAC, 1'b0);
        idle_until(130);
        check(pulse_n, 0, "R5 last-edge refresh wins");
        idle_until(265);
        check(pulse_at, 257, "R5 next period");

        tag = "R6";
        do_reset(1'b1, 3'd0, 1'b0);
        write_at(40, 8'h55, 1'b0);
        idle_until(45);
        check(pulse_at, 40, "R6 wrong byte");

        tag = "R7";
        do_reset(1'b1, 3'd1, 1'b0);
        write_at(50, 8'hAC, 1'b1);
        idle_until(55);
        check(pulse_at, 50, "R7 bit access with key");

        tag = "R8";
        do_reset(1'b0, 3'd0, 1'b0);
        write_at(100, 8'hAC, 1'b0);
        idle_until(1000);
        check(pulse_n, 0, "R8 disabled no pulse");
        tag = "R6";
        write_at(1010, 8'h00, 1'b0);
        idle_until(1015);
        check(pulse_at, 1010, "R6 wrong byte while stopped");

        tag = "R9";
        do_reset(1'b0, 3'd0, 1'b1);
        write_at(20, 8'hAC, 1'b0);
        idle_until(1000);
        check(pulse_n, 0, "R9 illegal options stay stopped");

        tag = "R10";
        do_reset(1'b1, 3'd0, 1'b0);
        idle_until(49);
        standby = 1'b1;
        idle_until(599);
        check(pulse_n, 0, "R10 frozen no pulse");
        standby = 1'b0;
        idle_until(740);
        check(pulse_at, 728, "R10 cleared on release");

        tag = "R11";
        do_reset(1'b1, 3'd0, 1'b1);
        idle_until(19);
        standby = 1'b1;
        idle_until(135);
        check(pulse_at, 129, "R11 standby run keeps period");
        standby = 1'b0;

        tag = "R2";
        do_reset(1'b1, 3'd7, 1'b0);
        idle_until(16390);
        check(pulse_at, 16385, "R2 sel7 period");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule